// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of an eight-line legacy interrupt controller. Software writes bytes to a command port and a data port. A command byte is classified by two bit tests into an initialization start word, a selection word or an operation word. Data bytes are routed either into the mask register or into the next step of a three- or four-word initialization sequence.

The block holds the vector base, the mask, the nested-mode and automatic end-of-interrupt bits, the register-read selection, the poll flag and the special-mask flag. It answers reads with the pending or in-service vector from the priority block, with the mask, or with a poll result. Priority resolution and end-of-interrupt handling are not part of this block. Operation words are handed to the priority block as a decoded one-cycle strobe. The start of initialization is also signalled by a strobe, so the priority block can clear its rotation base.

The sequencer has four states. SEQ_READY is the rest state. SEQ_BASE waits for the vector-base word. SEQ_CASC waits for the cascade word, whose value is discarded. SEQ_MODE waits for the mode word. Its transitions are:
- any state goes to SEQ_BASE on a start word;
- SEQ_BASE goes to SEQ_CASC on a data write;
- SEQ_CASC goes to SEQ_MODE on a data write if the mode word was requested, and to SEQ_READY on a data write otherwise;
- SEQ_MODE goes to SEQ_READY on a data write.

Top module: `irq_cmd_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in SEQ_READY and drives every register output, strobe and rd_data to zero.
- R2: A command-port byte with bit 4 set is a start word, even if bit 3 is also set. Otherwise, a byte with bit 3 set is a selection word. Every other command byte is an operation word. At most one kind is decoded per write.
- R3: A start word pulses init_stb for the one cycle after the write. It clears imr, special_mask and read_isr. It clears nested_mode and auto_eoi only when its bit 0 (mode word requested) is 0. The decoded state is visible in the cycle after the write.
- R4: The first data write after a start word sets vec_base to the byte with its low LVL_W bits cleared (byte AND 0xF8 by default). It does not change imr.
- R5: The second data write after a start word is discarded. After it, the next data write is the mode word if bit 0 of the start word was 1. Otherwise the next data write loads imr.
- R6: The mode word sets nested_mode from its bit 4 and auto_eoi from its bit 1. It returns the sequencer to SEQ_READY.
- R7: In SEQ_READY a data write loads imr. imr changes only in the cycle after a write.
- R8: In a selection word, bit 2 set arms the poll flag. Bit 1 set loads read_isr from bit 0 (1 selects in-service, 0 selects pending). Bit 6 set loads special_mask from bit 5. A flag whose enable bit is 0 keeps its value.
- R9: An operation word raises ocw2_stb for exactly the one cycle after the write. ocw2_cmd carries bits 7:5 and ocw2_lvl carries bits 2:0.
- R10: With the poll flag clear, a read returns its data one cycle after rd_en. A command-port read (rd_sel 0) returns isr_in when read_isr is 1 and irr_in when it is 0. A data-port read (rd_sel 1) returns imr. rd_data holds its value between reads.
- R11: With the poll flag set, a read of either port returns poll_in, clears the flag and pulses poll_ack for one cycle.
- R12: A start word received in the middle of a sequence restarts it. The next data write is again taken as the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 command port, 1 data port |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | One-cycle read strobe |
| rd_sel | input | 1 | Read target: 0 command port, 1 data port |
| irr_in | input | LINES | Pending vector from the priority block |
| isr_in | input | LINES | In-service vector from the priority block |
| poll_in | input | 8 | Poll answer from the priority block |
| rd_data | output | 8 | Read result, one cycle after rd_en |
| poll_ack | output | 1 | Pulse: a poll answer was consumed |
| vec_base | output | 8 | Interrupt vector base |
| imr | output | LINES | Interrupt mask register |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| read_isr | output | 1 | Command-port read selects in-service vector |
| special_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | Next read returns the poll answer |
| init_stb | output | 1 | Pulse: initialization started, clear rotation base |
| ocw2_stb | output | 1 | Pulse: operation word received |
| ocw2_cmd | output | 3 | Operation word command field |
| ocw2_lvl | output | LVL_W | Operation word level field |

## Verification
The bench builds the block with the default LVL_W of 3. This gives eight request lines and a vector-base mask of 0xF8, so bits written below bit 3 of the base word visibly disappear. At this width the mask, pending and in-service vectors fill the whole read byte, so each read path returns a full distinct pattern. Both the three-word and four-word sequences are driven, and a restart in the middle of a sequence is included. Start words that also carry the selection-word bit are part of the stimulus.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_READY = 2'd0,
        SEQ_BASE  = 2'd1,
        SEQ_CASC  = 2'd2,
        SEQ_MODE  = 2'd3
    } seq_t;

    typedef enum logic [1:0] {
        CMD_START  = 2'd0,
        CMD_SELECT = 2'd1,
        CMD_OPER   = 2'd2
    } cmd_kind_t;

    // bit positions that software and the priority block rely on
    localparam int B_START   = 4;
    localparam int B_SELECT  = 3;
    localparam int B_NEED4   = 0;
    localparam int B_NEST    = 4;
    localparam int B_AEOI    = 1;
    localparam int B_POLL    = 2;
    localparam int B_RD_EN   = 1;
    localparam int B_RD_ISR  = 0;
    localparam int B_SM_EN   = 6;
    localparam int B_SM_VAL  = 5;
    localparam int CMD_LSB   = 5;

endpackage

// File: rtl/irq_cmd_classify.sv
module irq_cmd_classify
    import irq_cmd_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [1:0] tag_bits,   // {start bit, select bit}
    output logic       start_wr,
    output logic       select_wr,
    output logic       oper_wr,
    output logic       data_wr
);
    cmd_kind_t kind;

    always_comb begin
        if (tag_bits[1])      kind = CMD_START;
        else if (tag_bits[0]) kind = CMD_SELECT;
        else                  kind = CMD_OPER;
    end

    always_comb begin
        start_wr  = 1'b0;
        select_wr = 1'b0;
        oper_wr   = 1'b0;
        data_wr   = wr_en && wr_sel;
        if (wr_en && !wr_sel) begin
            unique case (kind)
                CMD_START:  start_wr  = 1'b1;
                CMD_SELECT: select_wr = 1'b1;
                CMD_OPER:   oper_wr   = 1'b1;
                default:    oper_wr   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_cmd_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_wr,
    input  logic       data_wr,
    input  logic [7:0] wr_data,
    output logic       ready,
    output logic [7:0] vec_base,
    output logic       nested_mode,
    output logic       auto_eoi,
    output logic       init_stb
);
    localparam logic [7:0] BASE_MASK = 8'(~((1 << LVL_W) - 1));

    seq_t state, nxt;
    logic need4;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_READY;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_wr) begin
            nxt = SEQ_BASE;
        end else if (data_wr) begin
            unique case (state)
                SEQ_READY: nxt = SEQ_READY;
                SEQ_BASE:  nxt = SEQ_CASC;
                SEQ_CASC:  nxt = need4 ? SEQ_MODE : SEQ_READY;
                SEQ_MODE:  nxt = SEQ_READY;
                default:   nxt = SEQ_READY;
            endcase
        end
    end

    assign ready = (state == SEQ_READY);

    // outputs held by the sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            need4       <= 1'b0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
            init_stb    <= 1'b0;
        end else begin
            init_stb <= start_wr;
            if (start_wr) begin
                need4 <= wr_data[B_NEED4];
                if (!wr_data[B_NEED4]) begin
                    nested_mode <= 1'b0;
                    auto_eoi    <= 1'b0;
                end
            end else if (data_wr) begin
                unique case (state)
                    SEQ_BASE: vec_base <= wr_data & BASE_MASK;
                    SEQ_MODE: begin
                        nested_mode <= wr_data[B_NEST];
                        auto_eoi    <= wr_data[B_AEOI];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_op_regs.sv
module irq_op_regs
    import irq_cmd_pkg::*;
#(
    parameter int LVL_W = 3,
    localparam int LINES = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready,
    input  logic             start_wr,
    input  logic             select_wr,
    input  logic             oper_wr,
    input  logic             data_wr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [LINES-1:0] irr_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [7:0]       poll_in,
    output logic [7:0]       rd_data,
    output logic             poll_ack,
    output logic [LINES-1:0] imr,
    output logic             read_isr,
    output logic             special_mask,
    output logic             poll_armed,
    output logic             ocw2_stb,
    output logic [2:0]       ocw2_cmd,
    output logic [LVL_W-1:0] ocw2_lvl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data      <= '0;
            poll_ack     <= 1'b0;
            imr          <= '0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
            poll_armed   <= 1'b0;
            ocw2_stb     <= 1'b0;
            ocw2_cmd     <= '0;
            ocw2_lvl     <= '0;
        end else begin
            poll_ack <= 1'b0;
            ocw2_stb <= 1'b0;
            if (rd_en) begin
                if (poll_armed) begin
                    rd_data    <= poll_in;
                    poll_armed <= 1'b0;
                    poll_ack   <= 1'b1;
                end else if (rd_sel) begin
                    rd_data <= 8'(imr);
                end else begin
                    rd_data <= read_isr ? 8'(isr_in) : 8'(irr_in);
                end
            end
            if (start_wr) begin
                imr          <= '0;
                special_mask <= 1'b0;
                read_isr     <= 1'b0;
            end
            if (data_wr && ready) imr <= wr_data[LINES-1:0];
            if (select_wr) begin
                if (wr_data[B_POLL])  poll_armed   <= 1'b1;
                if (wr_data[B_RD_EN]) read_isr     <= wr_data[B_RD_ISR];
                if (wr_data[B_SM_EN]) special_mask <= wr_data[B_SM_VAL];
            end
            if (oper_wr) begin
                ocw2_stb <= 1'b1;
                ocw2_cmd <= wr_data[7:CMD_LSB];
                ocw2_lvl <= wr_data[LVL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq #(
    parameter int LVL_W = 3,
    localparam int LINES = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [LINES-1:0] irr_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [7:0]       poll_in,
    output logic [7:0]       rd_data,
    output logic             poll_ack,
    output logic [7:0]       vec_base,
    output logic [LINES-1:0] imr,
    output logic             nested_mode,
    output logic             auto_eoi,
    output logic             read_isr,
    output logic             special_mask,
    output logic             poll_armed,
    output logic             init_stb,
    output logic             ocw2_stb,
    output logic [2:0]       ocw2_cmd,
    output logic [LVL_W-1:0] ocw2_lvl
);
    logic start_wr, select_wr, oper_wr, data_wr, ready;

    irq_cmd_classify u_classify (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .tag_bits  (wr_data[4:3]),
        .start_wr  (start_wr),
        .select_wr (select_wr),
        .oper_wr   (oper_wr),
        .data_wr   (data_wr)
    );

    irq_init_seq #(.LVL_W(LVL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_wr    (start_wr),
        .data_wr     (data_wr),
        .wr_data     (wr_data),
        .ready       (ready),
        .vec_base    (vec_base),
        .nested_mode (nested_mode),
        .auto_eoi    (auto_eoi),
        .init_stb    (init_stb)
    );

    irq_op_regs #(.LVL_W(LVL_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .ready        (ready),
        .start_wr     (start_wr),
        .select_wr    (select_wr),
        .oper_wr      (oper_wr),
        .data_wr      (data_wr),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .irr_in       (irr_in),
        .isr_in       (isr_in),
        .poll_in      (poll_in),
        .rd_data      (rd_data),
        .poll_ack     (poll_ack),
        .imr          (imr),
        .read_isr     (read_isr),
        .special_mask (special_mask),
        .poll_armed   (poll_armed),
        .ocw2_stb     (ocw2_stb),
        .ocw2_cmd     (ocw2_cmd),
        .ocw2_lvl     (ocw2_lvl)
    );
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [1:0]       cmd_tag,
    input logic             rd_en,
    input logic [LINES-1:0] imr,
    input logic             special_mask,
    input logic             read_isr,
    input logic             poll_armed,
    input logic             init_stb,
    input logic             ocw2_stb,
    input logic             poll_ack
);
    // R2
    one_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !(init_stb && ocw2_stb));

    // R9
    ocw2_src_chk: assert property (@(posedge clk) disable iff (rst)
        ocw2_stb |-> $past(wr_en && !wr_sel && cmd_tag == 2'b00));

    // R3
    init_clear_chk: assert property (@(posedge clk) disable iff (rst)
        init_stb |-> (imr == '0 && !special_mask && !read_isr));

    // R11
    poll_ack_chk: assert property (@(posedge clk) disable iff (rst)
        poll_ack |-> $past(poll_armed && rd_en));

    // R7
    imr_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(imr) |-> $past(wr_en));
endmodule

bind irq_cmd_seq irq_cmd_seq_chk #(.LINES(LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .cmd_tag      (wr_data[4:3]),
    .rd_en        (rd_en),
    .imr          (imr),
    .special_mask (special_mask),
    .read_isr     (read_isr),
    .poll_armed   (poll_armed),
    .init_stb     (init_stb),
    .ocw2_stb     (ocw2_stb),
    .poll_ack     (poll_ack)
);

// File: tb/irq_cmd_seq_bench.sv
module irq_cmd_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0, irr_in = '0, isr_in = '0, poll_in = '0;
    logic [7:0] rd_data, vec_base, imr;
    logic       poll_ack, nested_mode, auto_eoi, read_isr, special_mask;
    logic       poll_armed, init_stb, ocw2_stb;
    logic [2:0] ocw2_cmd, ocw2_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    always #5 clk = ~clk;

    irq_cmd_seq u_irq_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .irr_in(irr_in), .isr_in(isr_in),
        .poll_in(poll_in), .rd_data(rd_data), .poll_ack(poll_ack),
        .vec_base(vec_base), .imr(imr), .nested_mode(nested_mode),
        .auto_eoi(auto_eoi), .read_isr(read_isr), .special_mask(special_mask),
        .poll_armed(poll_armed), .init_stb(init_stb), .ocw2_stb(ocw2_stb),
        .ocw2_cmd(ocw2_cmd), .ocw2_lvl(ocw2_lvl)
    );

    // behavioural reference
    int m_step, m_imr, m_base, m_rd, m_cmd, m_lvl;
    bit m_need4, m_nest, m_aeoi, m_risr, m_sm, m_poll, m_pack, m_init, m_o2;

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_imr = 0; m_base = 0; m_rd = 0; m_cmd = 0; m_lvl = 0;
            m_need4 = 0; m_nest = 0; m_aeoi = 0; m_risr = 0; m_sm = 0;
            m_poll = 0; m_pack = 0; m_init = 0; m_o2 = 0;
        end else begin
            m_pack = 0; m_init = 0; m_o2 = 0;
            if (rd_en) begin
                if (m_poll) begin
                    m_rd = poll_in; m_poll = 0; m_pack = 1;
                end else if (rd_sel) m_rd = m_imr;
                else m_rd = m_risr ? isr_in : irr_in;
            end
            if (wr_en && !wr_sel) begin
                if ((wr_data & 8'h10) != 0) begin
                    m_init = 1; m_step = 1; m_need4 = wr_data[0];
                    m_imr = 0; m_sm = 0; m_risr = 0;
                    if (!m_need4) begin m_nest = 0; m_aeoi = 0; end
                end else if ((wr_data & 8'h08) != 0) begin
                    if (wr_data[2]) m_poll = 1;
                    if (wr_data[1]) m_risr = wr_data[0];
                    if (wr_data[6]) m_sm = wr_data[5];
                end else begin
                    m_o2 = 1; m_cmd = wr_data / 32; m_lvl = wr_data % 8;
                end
            end else if (wr_en) begin
                case (m_step)
                    0: m_imr = wr_data;
                    1: begin m_base = (wr_data / 8) * 8; m_step = 2; end
                    2: m_step = m_need4 ? 3 : 0;
                    default: begin m_nest = wr_data[4]; m_aeoi = wr_data[1]; m_step = 0; end
                endcase
            end
            live = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            chk("R7 imr", imr, m_imr);
            chk("R4 vec_base", vec_base, m_base);
            chk("R6 nested_mode", nested_mode, m_nest);
            chk("R6 auto_eoi", auto_eoi, m_aeoi);
            chk("R8 read_isr", read_isr, m_risr);
            chk("R8 special_mask", special_mask, m_sm);
            chk("R8 poll_armed", poll_armed, m_poll);
            chk("R11 poll_ack", poll_ack, m_pack);
            chk("R3 init_stb", init_stb, m_init);
            chk("R9 ocw2_stb", ocw2_stb, m_o2);
            chk("R9 ocw2_cmd", ocw2_cmd, m_cmd);
            chk("R9 ocw2_lvl", ocw2_lvl, m_lvl);
            chk("R10 rd_data", rd_data, m_rd);
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 imr", imr, 0);
        chk("R1 vec_base", vec_base, 0);
        chk("R1 flags", {nested_mode, auto_eoi, read_isr, special_mask, poll_armed}, 0);
        chk("R1 strobes", {init_stb, ocw2_stb, poll_ack}, 0);
        chk("R1 rd_data", rd_data, 0);
        rst = 1'b0;

        // four-word sequence
        wr(0, 8'h11);
        chk("R3 init_stb pulse", init_stb, 1);
        wr(1, 8'h73);
        chk("R4 base masked", vec_base, 8'h70);
        chk("R4 imr untouched", imr, 0);
        wr(1, 8'hFF);
        wr(1, 8'h13);
        chk("R6 nested", nested_mode, 1);
        chk("R6 auto_eoi", auto_eoi, 1);
        wr(1, 8'h5A);
        chk("R7 imr load", imr, 8'h5A);

        wr(0, 8'h65);
        chk("R9 strobe", ocw2_stb, 1);
        chk("R9 cmd", ocw2_cmd, 3);
        chk("R9 lvl", ocw2_lvl, 5);
        @(negedge clk);
        chk("R9 strobe one cycle", ocw2_stb, 0);

        irr_in = 8'h12; isr_in = 8'h34; poll_in = 8'h83;
        wr(0, 8'h0B);
        rd(0);
        chk("R10 isr read", rd_data, 8'h34);
        rd(1);
        chk("R10 imr read", rd_data, 8'h5A);
        wr(0, 8'h68);
        chk("R8 special mask set", special_mask, 1);
        chk("R8 read_isr kept", read_isr, 1);
        wr(0, 8'h0C);
        chk("R8 poll armed", poll_armed, 1);
        rd(0);
        chk("R11 poll value", rd_data, 8'h83);
        chk("R11 poll disarmed", poll_armed, 0);
        wr(0, 8'h0C);
        rd(1);
        chk("R11 poll on data port", rd_data, 8'h83);
        rd(0);
        chk("R10 after poll", rd_data, 8'h34);
        wr(0, 8'h0A);
        rd(0);
        chk("R10 irr read", rd_data, 8'h12);

        // three-word sequence
        wr(0, 8'h10);
        chk("R3 mode cleared", {nested_mode, auto_eoi}, 0);
        chk("R3 imr cleared", imr, 0);
        chk("R3 special mask cleared", special_mask, 0);
        wr(1, 8'h2F);
        chk("R4 base 3-word", vec_base, 8'h28);
        wr(1, 8'h99);
        chk("R5 cascade ignored", imr, 0);
        wr(1, 8'h55);
        chk("R5 back to ready", imr, 8'h55);

        // restart mid-sequence
        wr(0, 8'h11);
        wr(1, 8'h20);
        wr(0, 8'h11);
        wr(1, 8'h48);
        chk("R12 restart base", vec_base, 8'h48);
        wr(1, 8'h00);
        wr(1, 8'h02);
        chk("R12 mode word after restart", {nested_mode, auto_eoi}, 2'b01);
        wr(1, 8'hC3);
        chk("R12 ready after restart", imr, 8'hC3);

        // start bit wins over select bit
        wr(0, 8'h1C);
        chk("R2 start wins", init_stb, 1);
        chk("R2 not poll", poll_armed, 0);
        wr(1, 8'h08);
        wr(1, 8'h00);
        wr(1, 8'h01);
        chk("R2 plain operation", imr, 8'h01);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule